// File: doc/BRIEF.md
# Vector Widening Shift-Left Unit

This unit takes one 128-bit source vector of narrow lanes and produces a 128-bit vector of lanes twice as wide. The lanes it reads come from the lower or the upper 64 bits of the source, as a half-select input chooses. Each lane is sign-extended or zero-extended, as a signedness input chooses. It is then shifted left by an immediate amount, or by exactly the source lane width when the fixed-shift mode is on.

Source lanes of 8, 16 and 32 bits are supported. One request is accepted on any cycle that `in_valid` is high. The result, an error flag and a valid flag are registered and appear on the following cycle. The size code 3 is rejected. It gives an error flag and an all-zero result.

Top module: `wsl_unit`

## Requirements
- R1: Size code `elem_sz` selects the source lane width N: 0 gives 8 bits (8 lanes), 1 gives 16 bits (4 lanes), 2 gives 32 bits (2 lanes). Result lane i occupies `out_data[i*2N +: 2N]`, and the result lanes fill all 128 output bits.
- R2: With `hi_half` low, source lane i is read from `src[i*N +: N]`, which is within bits 63:0.
- R3: With `hi_half` high, source lane i is read from `src[64 + i*N +: N]`, which is within bits 127:64.
- R4: With `is_signed` high, each source lane is sign-extended to 2N bits before the shift.
- R5: With `is_signed` low, each source lane is zero-extended to 2N bits before the shift.
- R6: With `full_shift` low, lanes shift left by the low log2(N) bits of `shamt`, giving 0 to N-1. Higher `shamt` bits have no effect. A shift of 0 gives a plain widen.
- R7: With `full_shift` high, every lane shifts left by exactly N, and `shamt` has no effect.
- R8: Size code 3 sets `out_err` and makes `out_data` all zero. For codes 0 to 2, `out_err` is low.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_data` and `out_err` belong to that request.
- R10: While `in_valid` is low, `out_data` and `out_err` keep their last values.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_data` and `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src | input | 128 | Source vector |
| elem_sz | input | 2 | Source lane size code |
| is_signed | input | 1 | 1: sign-extend, 0: zero-extend |
| hi_half | input | 1 | 1: read lanes from bits 127:64 |
| full_shift | input | 1 | 1: shift by lane width, ignore shamt |
| shamt | input | 5 | Immediate shift amount |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_data | output | 128 | Widened, shifted result |
| out_err | output | 1 | Illegal size code seen |

## Verification
The output register is the only state. A wrong register shows at the ports on the cycle right after the request, as a wrong lane value, a lost valid pulse, or data that drifts while the input is idle. The other errors are in the combinational lane mapping: a wrong half, a wrong extension bit or a wrong shift mask. Each of these corrupts particular result lanes in that same next cycle. Random requests across all size, sign, half and mode settings are compared lane for lane against a reference model. Directed cases cover the sign boundary, out-of-range shift bits, the fixed-shift mode and the illegal size code.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
    localparam int VEC_W   = 128;
    localparam int HALF_W  = VEC_W / 2;
    localparam int MAX_EW  = 32;
    localparam int SHAMT_W = $clog2(MAX_EW);
    localparam int N_SIZES = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } wsl_size_e;

    typedef struct packed {
        logic             err;
        logic [VEC_W-1:0] data;
    } wsl_result_t;

    function automatic int lane_width(input int code);
        return 8 << code;
    endfunction
endpackage

// File: rtl/wsl_widen_lanes.sv
module wsl_widen_lanes #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8,
    parameter int SHW    = $clog2(ELEM_W) + 1
) (
    input  logic [VEC_W/2-1:0] half_i,
    input  logic               sgn_i,
    input  logic [SHW-1:0]     sh_i,
    output logic [VEC_W-1:0]   res_o
);
    localparam int WIDE_W = 2 * ELEM_W;
    localparam int LANES  = VEC_W / WIDE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ELEM_W-1:0] narrow;
        logic [WIDE_W-1:0] wide;
        assign narrow = half_i[i*ELEM_W +: ELEM_W];
        assign wide   = {{ELEM_W{sgn_i & narrow[ELEM_W-1]}}, narrow};
        assign res_o[i*WIDE_W +: WIDE_W] = wide << sh_i;
    end
endmodule

// File: rtl/wsl_unit.sv
module wsl_unit
    import wsl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   src,
    input  logic [1:0]         elem_sz,
    input  logic               is_signed,
    input  logic               hi_half,
    input  logic               full_shift,
    input  logic [SHAMT_W-1:0] shamt,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_data,
    output logic               out_err
);
    logic [HALF_W-1:0] half_sel;
    logic [VEC_W-1:0]  var_res [N_SIZES];
    wsl_result_t       next_res;
    wsl_size_e         sz;

    assign half_sel = hi_half ? src[VEC_W-1:HALF_W] : src[HALF_W-1:0];
    assign sz       = wsl_size_e'(elem_sz);

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int EW  = lane_width(g);
        localparam int LGW = $clog2(EW);
        localparam int SHW = LGW + 1;
        logic [SHW-1:0] eff_sh;
        assign eff_sh = full_shift ? SHW'(EW) : {1'b0, shamt[LGW-1:0]};
        wsl_widen_lanes #(.VEC_W(VEC_W), .ELEM_W(EW), .SHW(SHW)) u_lanes (
            .half_i(half_sel),
            .sgn_i (is_signed),
            .sh_i  (eff_sh),
            .res_o (var_res[g])
        );
    end

    always_comb begin
        next_res = '0;
        case (sz)
            SZ_BYTE: next_res.data = var_res[0];
            SZ_HALF: next_res.data = var_res[1];
            SZ_WORD: next_res.data = var_res[2];
            default: next_res.err  = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_res.data;
                out_err  <= next_res.err;
            end
        end
    end

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_err)));
    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_data == '0));
    // R8
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_sz == 2'd3) |=> out_err);
endmodule

// File: tb/wsl_unit_bench.sv
module wsl_unit_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] src;
    logic [1:0]   elem_sz;
    logic         is_signed, hi_half, full_shift;
    logic [4:0]   shamt;
    logic         out_valid, out_err;
    logic [127:0] out_data;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wsl_unit u_wsl_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .elem_sz(elem_sz),
        .is_signed(is_signed), .hi_half(hi_half), .full_shift(full_shift),
        .shamt(shamt), .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
    );

    function automatic logic [127:0] model(input logic [127:0] s, input int sz,
                                           input logic sg, input logic hi,
                                           input logic fs, input int sh);
        logic [127:0] r = '0;
        if (sz == 3) return r;
        begin
            int ew = 8 << sz;
            int n  = 8 >> sz;
            int amt = fs ? ew : (sh % ew);
            for (int i = 0; i < n; i++) begin
                logic [127:0] e = '0;
                for (int b = 0; b < ew; b++) e[b] = s[(hi ? 64 : 0) + i*ew + b];
                if (sg && e[ew-1]) for (int b = ew; b < 2*ew; b++) e[b] = 1'b1;
                e = e << amt;
                for (int b = 0; b < 2*ew; b++) r[i*2*ew + b] = e[b];
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [127:0] s, input int sz, input logic sg,
                       input logic hi, input logic fs, input int sh);
        @(negedge clk);
        in_valid = 1'b1; src = s; elem_sz = 2'(sz); is_signed = sg;
        hi_half = hi; full_shift = fs; shamt = 5'(sh);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " data"}, out_data, model(s, sz, sg, hi, fs, sh));
        check("R9 valid", {127'd0, out_valid}, 128'd1);
        check("R8 err", {127'd0, out_err}, {127'd0, (sz == 3)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic [127:0] held;
        seed = $urandom(32'd1234);
        rst = 1'b1; in_valid = 1'b0; src = '1; elem_sz = 2'd0;
        is_signed = 1'b0; hi_half = 1'b0; full_shift = 1'b0; shamt = '0;
        repeat (3) @(negedge clk);
        // R11
        check("R11 reset valid", {127'd0, out_valid}, 128'd0);
        check("R11 reset data", out_data, 128'd0);
        check("R11 reset err", {127'd0, out_err}, 128'd0);
        rst = 1'b0;

        // R1 R2 R5: plain widen, low half, unsigned
        run("R1 R2 R5 byte", 128'h0_0000_0000_0000_0000_8070_6050_4030_2010 | 128'h1, 0, 0, 0, 0, 0);
        check("R1 lane7 pos", out_data[127:112], 16'h0080);
        run("R1 half lanes", 128'h0000_0000_0000_0000_ffff_8001_1234_abcd, 1, 0, 0, 0, 0);
        // R3: upper half
        run("R3 upper", 128'hdead_beef_8000_0001_0000_0000_0000_0000, 2, 0, 1, 0, 0);
        check("R3 upper lane1", out_data[127:64], 64'h0000_0000_dead_beef);
        // R4: sign extension
        run("R4 signed", 128'h0000_0000_0000_0000_8000_0000_7fff_ffff, 2, 1, 0, 0, 0);
        check("R4 neg lane", out_data[127:64], 64'hffff_ffff_8000_0000);
        run("R4 signed byte shift", {64'd0, 64'h80ff_7f01_fe02_81c0}, 0, 1, 0, 0, 7);
        // R6: high shamt bits ignored (byte uses 3 bits: 5'b11011 -> 3)
        run("R6 mask", {64'd0, 64'h0102_0304_0506_0708}, 0, 0, 0, 0, 27);
        check("R6 shift3 lane0", out_data[15:0], 16'h0040);
        run("R6 max", {64'd0, 64'hffff_ffff_ffff_ffff}, 2, 1, 0, 0, 31);
        // R7: full shift ignores shamt
        run("R7 full", {64'd0, 64'h0000_0001_ffff_ffff}, 2, 1, 0, 1, 13);
        check("R7 lane0", out_data[63:0], 64'hffff_ffff_0000_0000);
        run("R7 full half", {64'h8001_0002_0003_0004, 64'd0}, 1, 0, 1, 1, 5);
        // R8: illegal size
        run("R8 bad size", '1, 3, 1, 1, 0, 4);

        // R10: idle hold
        held = out_data;
        @(negedge clk);
        src = ~src; elem_sz = 2'd0; shamt = 5'd1;
        @(negedge clk);
        check("R10 hold data", out_data, held);
        check("R10 hold err", {127'd0, out_err}, 128'd1);
        check("R9 idle valid", {127'd0, out_valid}, 128'd0);

        // random mix
        for (int k = 0; k < 400; k++) begin
            run("R1 random", {$urandom, $urandom, $urandom, $urandom}, int'($urandom % 4),
                1'($urandom), 1'($urandom), 1'(($urandom % 4) == 0), int'($urandom % 32));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule